// File: doc/BRIEF.md
# Serial Ethernet Address Field Extractor

This block sits beside a 10 Mb/s Ethernet receiver that supplies NRZ serial data and a recovered serial clock. Both are brought into a faster system clock domain, and the data is sampled on each rising edge of the serial clock. The block looks for the preamble and the start-of-frame delimiter. It then cuts the 48-bit destination address and the 48-bit source address into 16-bit words. Each word goes out on a valid/ready stream to a CAM-loading agent, which can start an address compare after the final word of each address.

Every output word carries a segment number. Numbers 0 to 2 are the destination address and numbers 3 to 5 are the source address. A one-cycle pulse marks the acceptance of the last word of each address.

The block also watches the serial clock for loss of carrier and watches a collision input. Both conditions raise the same one-cycle event.

**Back-pressure rules.** A word is held on `o_data`/`o_seg` with `o_valid` high until the cycle in which `o_ready` is high. The serial stream cannot be stalled. If a further word completes while a word is still held, the new word is discarded and the held word stays in place.

Top module: `eth_addr_extract`

## Requirements
- R1: Address assembly starts only after the pair of consecutive 1 bits that ends the delimiter, and only if at least MIN_PRE_BITS (default 6) alternating bits come right before that pair. A shorter run of alternating bits followed by 1,1 produces no words.
- R2: Serial bits arrive least significant bit first within each byte. In each 16-bit word, the first received byte is placed in bits 15:8 and the second in bits 7:0.
- R3: Each frame yields six words in order. Segment numbers 0, 1 and 2 are the destination address and 3, 4 and 5 are the source address, each address sent most significant word first.
- R4: `last_da_word` is high for exactly the one cycle in which segment 2 is accepted. `last_sa_word` does the same for segment 5.
- R5: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_data` and `o_seg` hold steady. A word that completes during that time is discarded.
- R6: `link_evt` pulses once when the synchronised serial clock stays low for more than LOC_LIMIT (default 16) consecutive system clocks. A low phase of 14 cycles inside a frame raises no event and does not disturb the frame.
- R7: A rising edge on `col_det` pulses `link_evt`. No further words are produced until the next loss of carrier.
- R8: After a loss of carrier the block hunts for a new delimiter, and the next frame is decoded in full.
- R9: During and straight after reset, `o_valid`, `last_da_word`, `last_sa_word` and `link_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Recovered serial clock (asynchronous) |
| ser_dat | input | 1 | NRZ serial data, stable around the rising edge of ser_clk |
| col_det | input | 1 | Collision indication (asynchronous) |
| o_valid | output | 1 | An address word is held on o_data |
| o_ready | input | 1 | Consumer accepts the held word this cycle |
| o_data | output | 16 | Address word |
| o_seg | output | 3 | Segment number 0..5 |
| last_da_word | output | 1 | Pulse: last destination word accepted |
| last_sa_word | output | 1 | Pulse: last source word accepted |
| link_evt | output | 1 | Pulse: loss of carrier or collision |

## Verification
The bench sends a preamble that is too short and is followed by 1,1. A design that only looks for two 1s would start emitting words from the bytes that follow. Known address patterns catch byte swaps and bit reversal, which show up as wrong word values. The bench holds `o_ready` low for a whole frame: a design that overwrites its held word would hand over a later segment instead of segment 0. A collision in the middle of a frame, a stretched low phase just under the threshold, and a frame after each event check that the block neither keeps emitting nor fails to restart, and that a normal clock gap does not raise the event.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ADDR = 2'd1,
    ST_DONE = 2'd2
  } rx_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/eaddr_sync.sv
module eaddr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/eaddr_link_mon.sv
module eaddr_link_mon #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_clk,
  input  logic s_col,
  output logic lc_hit,
  output logic col_hit,
  output logic evt
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] lo_cnt;
  logic          col_q;

  // lo_cnt counts earlier low cycles; the (LIMIT+1)-th low cycle fires
  assign lc_hit  = !s_clk && (lo_cnt == CW'(LIMIT));
  assign col_hit = s_col && !col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      col_q  <= 1'b0;
      evt    <= 1'b0;
    end else begin
      col_q <= s_col;
      evt   <= lc_hit | col_hit;
      if (s_clk)                        lo_cnt <= '0;
      else if (lo_cnt != CW'(LIMIT + 1)) lo_cnt <= lo_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eaddr_deser.sv
module eaddr_deser
  import eaddr_pkg::*;
#(
  parameter int ADDR_BITS    = 48,
  parameter int WORD_W       = 16,
  parameter int MIN_PRE_BITS = 6,
  parameter int SEGW         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_dat,
  input  logic              lc_hit,
  input  logic              col_hit,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic [SEGW-1:0]   push_seg
);
  localparam int TOTAL = 2 * ADDR_BITS;
  localparam int BCW   = $clog2(TOTAL);
  localparam int PCW   = $clog2(MIN_PRE_BITS + 1);

  rx_state_t         st;
  logic              clk_q;
  logic              last_bit;
  logic [PCW-1:0]    alt_cnt;
  logic [BCW-1:0]    bit_cnt;
  logic [WORD_W-1:0] acc, acc_nxt;
  logic              word_end;
  logic [SEGW-1:0]   seg_now;

  wire bit_stb = s_clk && !clk_q;

  // LSB-first bytes; first byte of a word lands in the upper byte lane
  function automatic int lane_pos(input int k);
    return WORD_W - BYTE_W * (k / BYTE_W + 1) + (k % BYTE_W);
  endfunction

  always_comb begin
    int kk;
    kk       = int'(bit_cnt) % WORD_W;
    acc_nxt  = acc;
    acc_nxt[lane_pos(kk)] = s_dat;
    word_end = (kk == WORD_W - 1);
    seg_now  = SEGW'(int'(bit_cnt) / WORD_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HUNT;
      clk_q     <= 1'b0;
      last_bit  <= 1'b0;
      alt_cnt   <= '0;
      bit_cnt   <= '0;
      acc       <= '0;
      push      <= 1'b0;
      push_data <= '0;
      push_seg  <= '0;
    end else begin
      clk_q <= s_clk;
      push  <= 1'b0;
      if (lc_hit) begin
        st       <= ST_HUNT;
        alt_cnt  <= '0;
        last_bit <= 1'b0;
        bit_cnt  <= '0;
      end else if (col_hit) begin
        st <= ST_DONE;
      end else if (bit_stb) begin
        unique case (st)
          ST_HUNT: begin
            last_bit <= s_dat;
            if (s_dat != last_bit) begin
              if (alt_cnt != PCW'(MIN_PRE_BITS)) alt_cnt <= alt_cnt + 1'b1;
            end else if (s_dat && alt_cnt == PCW'(MIN_PRE_BITS)) begin
              st      <= ST_ADDR;
              bit_cnt <= '0;
              alt_cnt <= '0;
            end else begin
              alt_cnt <= '0;
            end
          end
          ST_ADDR: begin
            acc <= acc_nxt;
            if (word_end) begin
              push      <= 1'b1;
              push_data <= acc_nxt;
              push_seg  <= seg_now;
            end
            if (bit_cnt == BCW'(TOTAL - 1)) st <= ST_DONE;
            else                            bit_cnt <= bit_cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eaddr_hold.sv
module eaddr_hold #(
  parameter int WORD_W = 16,
  parameter int SEGW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic [SEGW-1:0]   push_seg,
  input  logic              o_ready,
  output logic              o_valid,
  output logic [WORD_W-1:0] o_data,
  output logic [SEGW-1:0]   o_seg
);
  wire take = push && (!o_valid || o_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_seg   <= '0;
    end else if (take) begin
      o_valid <= 1'b1;
      o_data  <= push_data;
      o_seg   <= push_seg;
    end else if (o_valid && o_ready) begin
      o_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_addr_extract.sv
module eth_addr_extract #(
  parameter int ADDR_BITS    = 48,
  parameter int WORD_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int LOC_LIMIT    = 16,
  parameter int MIN_PRE_BITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        col_det,
  output logic        o_valid,
  input  logic        o_ready,
  output logic [15:0] o_data,
  output logic [2:0]  o_seg,
  output logic        last_da_word,
  output logic        last_sa_word,
  output logic        link_evt
);
  localparam int SEGS = ADDR_BITS / WORD_W;
  localparam int SEGW = $clog2(2 * SEGS);

  logic [2:0]        sync_q;
  logic              lc_hit, col_hit, push;
  logic [WORD_W-1:0] push_data;
  logic [SEGW-1:0]   push_seg;

  eaddr_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({ser_clk, ser_dat, col_det}), .q(sync_q)
  );

  eaddr_link_mon #(.LIMIT(LOC_LIMIT)) mon_i (
    .clk(clk), .rst_n(rst_n), .s_clk(sync_q[2]), .s_col(sync_q[0]),
    .lc_hit(lc_hit), .col_hit(col_hit), .evt(link_evt)
  );

  eaddr_deser #(
    .ADDR_BITS(ADDR_BITS), .WORD_W(WORD_W),
    .MIN_PRE_BITS(MIN_PRE_BITS), .SEGW(SEGW)
  ) deser_i (
    .clk(clk), .rst_n(rst_n), .s_clk(sync_q[2]), .s_dat(sync_q[1]),
    .lc_hit(lc_hit), .col_hit(col_hit),
    .push(push), .push_data(push_data), .push_seg(push_seg)
  );

  eaddr_hold #(.WORD_W(WORD_W), .SEGW(SEGW)) hold_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_seg(push_seg), .o_ready(o_ready),
    .o_valid(o_valid), .o_data(o_data), .o_seg(o_seg)
  );

  wire accept = o_valid && o_ready;
  assign last_da_word = accept && (o_seg == 3'(SEGS - 1));
  assign last_sa_word = accept && (o_seg == 3'(2 * SEGS - 1));
endmodule

// File: rtl/eaddr_chk.sv
module eaddr_chk #(
  parameter int SEGS = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        o_valid,
  input logic        o_ready,
  input logic [15:0] o_data,
  input logic [2:0]  o_seg,
  input logic        last_da_word,
  input logic        last_sa_word,
  input logic        link_evt
);
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_seg)));

  // R4
  last_da_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_da_word |=> !last_da_word);

  // R4
  last_sa_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_sa_word |=> !last_sa_word);

  // R3
  seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_seg < 3'(2 * SEGS)));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!o_valid && !link_evt && !last_da_word && !last_sa_word));
endmodule

bind eth_addr_extract eaddr_chk #(.SEGS(ADDR_BITS / WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready),
  .o_data(o_data), .o_seg(o_seg), .last_da_word(last_da_word),
  .last_sa_word(last_sa_word), .link_evt(link_evt)
);

// File: tb/eth_addr_extract_tb_top.sv
module eth_addr_extract_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, col_det = 1'b0;
  logic o_valid, o_ready, last_da_word, last_sa_word, link_evt;
  logic [15:0] o_data;
  logic [2:0]  o_seg;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 0;   // 0 always ready, 1 random, 2 held low
  int got_n = 0, evt_n = 0;
  logic [15:0] got_data [16];
  logic [2:0]  got_seg  [16];
  logic        got_lda  [16];
  logic        got_lsa  [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_addr_extract dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .col_det(col_det), .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
    .o_seg(o_seg), .last_da_word(last_da_word), .last_sa_word(last_sa_word),
    .link_evt(link_evt)
  );

  initial o_ready = 1'b1;

  // consumer + observer: set ready, then sample what the next edge will see
  always @(negedge clk) begin
    if (rdy_mode == 0)      o_ready = 1'b1;
    else if (rdy_mode == 1) o_ready = 1'($urandom % 2);
    else                    o_ready = 1'b0;
    #1;
    if (rst_n && o_valid && o_ready && got_n < 16) begin
      got_data[got_n] = o_data;
      got_seg[got_n]  = o_seg;
      got_lda[got_n]  = last_da_word;
      got_lsa[got_n]  = last_sa_word;
      got_n++;
    end
    if (rst_n && link_evt) evt_n++;
  end

  task automatic chk(input logic ok, input string tag, input logic [47:0] act,
                     input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int lo);
    ser_clk = 1'b0;
    ser_dat = b;
    repeat (lo) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_frame();
    ser_clk = 1'b0;
    col_det = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic send_frame(input logic [47:0] da, input logic [47:0] sa,
                            input int gap_at, input int gap_len, input int col_at);
    logic [95:0] addr;
    addr = {da, sa};
    @(negedge clk);
    for (int i = 0; i < 56; i++) send_bit(1'(~i & 1), 4);
    for (int i = 0; i < 8; i++)  send_bit(1'((8'hD5 >> i) & 1), 4);
    for (int n = 0; n < 96; n++) begin
      int byte_i, bit_i;
      byte_i = n / 8;
      bit_i  = n % 8;
      if (n == col_at) col_det = 1'b1;
      send_bit(addr[95 - 8*byte_i - 7 + bit_i], (n == gap_at) ? gap_len : 4);
    end
    for (int n = 0; n < 64; n++) send_bit(1'($urandom % 2), 4);
    end_frame();
  endtask

  task automatic verify(input logic [47:0] da, input logic [47:0] sa, input int nexp);
    logic [95:0] addr;
    addr = {da, sa};
    chk(got_n == nexp, "R3 word count", 48'(got_n), 48'(nexp));
    for (int i = 0; i < nexp && i < got_n; i++) begin
      chk(got_data[i] == addr[95 - 16*i -: 16], "R2 word value",
          48'(got_data[i]), 48'(addr[95 - 16*i -: 16]));
      chk(got_seg[i] == 3'(i), "R3 segment order", 48'(got_seg[i]), 48'(i));
      chk(got_lda[i] == (i == 2), "R4 last_da_word", 48'(got_lda[i]), 48'(i == 2));
      chk(got_lsa[i] == (i == 5), "R4 last_sa_word", 48'(got_lsa[i]), 48'(i == 5));
    end
  endtask

  function automatic logic [47:0] rnd48();
    return {16'($urandom), 32'($urandom)};
  endfunction

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] da, sa;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!o_valid && !link_evt && !last_da_word && !last_sa_word, "R9 reset idle",
        {o_valid, link_evt, last_da_word, last_sa_word}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!o_valid && !link_evt, "R9 after release", {o_valid, link_evt}, 0);
    repeat (40) @(negedge clk);

    // R2 R3 R4 R6 R8: directed frames
    for (int f = 0; f < 2; f++) begin
      da = f == 0 ? 48'h0123_4567_89AB : 48'h8000_0000_0001;
      sa = f == 0 ? 48'hFEDC_BA98_7654 : 48'h7FFF_FFFF_FFFE;
      got_n = 0; evt_n = 0;
      send_frame(da, sa, -1, 4, -1);
      verify(da, sa, 6);
      chk(evt_n == 1, "R6 one carrier event per frame end", 48'(evt_n), 1);
    end

    // R5 R8: random addresses with random back-pressure
    rdy_mode = 1;
    for (int f = 0; f < 4; f++) begin
      da = rnd48(); sa = rnd48();
      got_n = 0; evt_n = 0;
      send_frame(da, sa, -1, 4, -1);
      repeat (10) @(negedge clk);
      verify(da, sa, 6);
    end
    rdy_mode = 0;

    // R6: stretched low phase below threshold inside frame
    da = rnd48(); sa = rnd48();
    got_n = 0; evt_n = 0;
    send_frame(da, sa, 20, 14, -1);
    verify(da, sa, 6);
    chk(evt_n == 1, "R6 short gap no event", 48'(evt_n), 1);

    // R5: consumer stalls for the whole frame
    da = 48'hA1B2_C3D4_E5F6; sa = rnd48();
    got_n = 0;
    rdy_mode = 2;
    send_frame(da, sa, -1, 4, -1);
    chk(got_n == 0, "R5 nothing accepted while stalled", 48'(got_n), 0);
    chk(o_valid && o_data == 16'hA1B2 && o_seg == 3'd0, "R5 first word held",
        {o_valid, o_seg, o_data}, {1'b1, 3'd0, 16'hA1B2});
    rdy_mode = 0;
    repeat (20) @(negedge clk);
    chk(got_n == 1, "R5 later words dropped", 48'(got_n), 1);
    chk(got_data[0] == 16'hA1B2, "R5 held word value", 48'(got_data[0]), 48'hA1B2);

    // R1: preamble too short before 1,1, then zeros
    got_n = 0; evt_n = 0;
    @(negedge clk);
    send_bit(1, 4); send_bit(0, 4); send_bit(1, 4); send_bit(0, 4);
    send_bit(1, 4); send_bit(1, 4);
    for (int n = 0; n < 96; n++) send_bit(0, 4);
    end_frame();
    chk(got_n == 0, "R1 short preamble rejected", 48'(got_n), 0);
    chk(evt_n == 1, "R6 event after short frame", 48'(evt_n), 1);

    // R7: collision at the first source bit
    da = rnd48(); sa = rnd48();
    got_n = 0; evt_n = 0;
    send_frame(da, sa, -1, 4, 48);
    verify(da, sa, 3);
    chk(evt_n == 2, "R7 collision plus carrier events", 48'(evt_n), 2);

    // R8: recovery after collision and carrier loss
    da = rnd48(); sa = rnd48();
    got_n = 0; evt_n = 0;
    send_frame(da, sa, -1, 4, -1);
    verify(da, sa, 6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule